// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block moves outgoing data from host memory into a byte stream. The data is described by a linked list of four-word descriptors. Each descriptor names a data buffer and a byte count, points to the next descriptor, and carries a flag that tells the engine to stop once the descriptor is finished. The engine reads the descriptor, streams its bytes lowest-first, writes a status word back, pulses a completion interrupt and then moves on. It moves on either at once or, when the stop flag is set, only after the host clears that flag and sends a poll strobe.

A descriptor with a zero byte count moves no data. This lets software use one fixed dummy descriptor as a changeable link between lists. The host can restart the walk at any time with an init strobe, which takes the list head from the `base_addr` input. The memory port allows one request at a time: reads are answered later by a response pulse, and writes complete when they are accepted.

Top module: `txd_chain_dma`

## Requirements
- R1: After reset the block issues no memory request, presents no byte and raises no interrupt until an init strobe arrives.
- R2: An init strobe makes the next descriptor read go to `base_addr`. It abandons any descriptor that is part way through streaming, so no status is written for that descriptor.
- R3: The descriptor at address A is read in this order: control word at A, then next pointer at A+4, then buffer address at A+8. The control word holds the stop flag in bit 31 and the byte count in bits 15:0.
- R4: The data buffer is read as ceil(count/4) word reads at consecutive word addresses. Each word is emitted least significant byte first, and only the bytes still owed are taken from the final word.
- R5: After the last byte of a descriptor is accepted, the block writes status to A+12. The status has bit 31 set, the byte count in bits 15:0, and all other bits zero.
- R6: Every completed descriptor, zero-length ones included, gives exactly one one-cycle pulse on `irq_done`, in the cycle after its status write is accepted.
- R7: When a descriptor completes with its stop flag clear, the next descriptor fetched is the one at the next pointer read from that descriptor.
- R8: When a descriptor completes with its stop flag set, the block parks on it and issues no memory request while no poll is pending.
- R9: A poll while parked re-reads only A and A+4 of the held descriptor. If the fresh stop flag is clear, the block branches to the freshly read pointer. Otherwise it parks again, with no new status write and no new interrupt.
- R10: A poll strobe that arrives while the block is still working on a descriptor is remembered, and it starts the re-read as soon as the block parks.
- R11: A zero-length descriptor makes no buffer-address or data read, but still gets its status write and interrupt. A dummy descriptor whose pointer is its own address may be walked repeatedly.
- R12: A memory request keeps its address, direction and write data until it is accepted. A presented byte keeps its value until it is accepted, unless an init strobe intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | One-cycle strobe: restart the walk at base_addr |
| base_addr | input | AW | Address of the first descriptor of the list |
| poll_req | input | 1 | One-cycle strobe: re-examine a held descriptor |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the word |
| mem_req_wdata | output | DW | Status word to write |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | DW | Read data |
| out_valid | output | 1 | A byte is presented |
| out_ready | input | 1 | The byte is taken this cycle |
| out_data | output | 8 | Byte value |
| irq_done | output | 1 | One-cycle pulse per completed descriptor |

## Verification
The hardest case to reach from the ports is a poll strobe that lands while the engine is still streaming a descriptor whose stop flag it has already fetched. To get there, the stimulus watches the log of read addresses. Once the buffer-address read has gone out, it clears the flag in memory and pulses the poll, and the data that follows must come from the next descriptor. A second hard case is an init strobe that arrives while a byte is waiting. The stimulus holds the byte stream stalled across that init, so every byte seen afterwards can be traced to the new list.

// File: rtl/txd_pkg.sv
package txd_pkg;
   // walker states; order carries no meaning
   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_CTL, S_WT_CTL,
      S_RD_NXT, S_WT_NXT,
      S_RD_BUF, S_WT_BUF,
      S_RD_DAT, S_WT_DAT,
      S_EMIT,
      S_WR_STS,
      S_DONE,
      S_PARK
   } walk_st_t;

   // word index of each descriptor field
   localparam int unsigned W_CTL = 0;
   localparam int unsigned W_NXT = 1;
   localparam int unsigned W_BUF = 2;
   localparam int unsigned W_STS = 3;
endpackage

// File: rtl/txd_cmd_latch.sv
// Holds one pending poll and one pending init, each until the walker takes it.
module txd_cmd_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic poll_req,
   input  logic init_req,
   input  logic poll_take,
   input  logic init_take,
   output logic poll_pend,
   output logic init_pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_pend <= 1'b0;
         init_pend <= 1'b0;
      end else begin
         // an init discards any outstanding poll (R2); otherwise a new poll wins over a take (R10)
         if (init_take)      poll_pend <= 1'b0;
         else if (poll_req)  poll_pend <= 1'b1;
         else if (poll_take) poll_pend <= 1'b0;

         if (init_req)       init_pend <= 1'b1;
         else if (init_take) init_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/txd_unpack.sv
// Emits up to DW/8 bytes of a loaded word, least significant first (R4).
module txd_unpack #(
   parameter int DW         = 32,
   parameter bit SHIFT_MODE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [DW-1:0]                 word,
   input  logic [$clog2(DW/8+1)-1:0]     nbytes,
   input  logic                          flush,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [7:0]                    out_data,
   output logic                          busy
);
   localparam int BPW  = DW / 8;
   localparam int NBW  = $clog2(BPW + 1);
   localparam int OFSH = $clog2(BPW);

   logic [NBW-1:0] left_q;
   logic           accept;

   assign out_valid = (left_q != '0);
   assign busy      = out_valid;
   assign accept    = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (flush)  left_q <= '0;
      else if (load)   left_q <= nbytes;
      else if (accept) left_q <= left_q - NBW'(1);
   end

   generate
      if (SHIFT_MODE) begin : g_shift
         logic [DW-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sh_q <= '0;
            else if (load)   sh_q <= word;
            else if (accept) sh_q <= sh_q >> 8;
         end
         assign out_data = sh_q[7:0];
      end else begin : g_mux
         logic [DW-1:0]   wd_q;
         logic [OFSH-1:0] idx_q;
         logic [7:0]      lanes [BPW];
         for (genvar g = 0; g < BPW; g++) begin : g_lane
            assign lanes[g] = wd_q[8*g +: 8];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wd_q  <= '0;
               idx_q <= '0;
            end else if (load) begin
               wd_q  <= word;
               idx_q <= '0;
            end else if (accept) begin
               idx_q <= idx_q + OFSH'(1);
            end
         end
         assign out_data = lanes[idx_q];
      end
   endgenerate
endmodule

// File: rtl/txd_walker.sv
// Descriptor list sequencer: fetch, stream, write back, follow or park.
module txd_walker
   import txd_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [AW-1:0]                 base_addr,
   input  logic                          poll_pend,
   input  logic                          init_pend,
   output logic                          poll_take,
   output logic                          init_take,
   output logic                          req_valid,
   input  logic                          req_ready,
   output logic                          req_we,
   output logic [AW-1:0]                 req_addr,
   output logic [DW-1:0]                 req_wdata,
   input  logic                          rsp_valid,
   input  logic [DW-1:0]                 rsp_data,
   output logic                          up_load,
   output logic [DW-1:0]                 up_word,
   output logic [$clog2(DW/8+1)-1:0]     up_nbytes,
   output logic                          up_flush,
   input  logic                          up_busy,
   output logic                          irq,
   output logic                          parked
);
   localparam int BPW  = DW / 8;
   localparam int NBW  = $clog2(BPW + 1);
   localparam int OFSH = $clog2(BPW);
   localparam logic [AW-1:0] OFS_NXT = AW'(W_NXT * BPW);
   localparam logic [AW-1:0] OFS_BUF = AW'(W_BUF * BPW);
   localparam logic [AW-1:0] OFS_STS = AW'(W_STS * BPW);
   localparam logic [AW-1:0] WSTEP   = AW'(BPW);

   walk_st_t        st_q;
   logic [AW-1:0]   cur_q, nxt_q, dptr_q;
   logic [CW-1:0]   cnt_q, rem_q;
   logic            hold_q, recheck_q;
   logic [NBW-1:0]  take_n;

   // init is honoured only where no memory transfer is in flight (R2, R12)
   assign init_take = init_pend &&
                      (st_q inside {S_IDLE, S_PARK, S_EMIT, S_DONE});
   assign poll_take = (st_q == S_PARK) && poll_pend && !init_take;

   assign take_n = (rem_q < CW'(BPW)) ? NBW'(rem_q) : NBW'(BPW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         cur_q     <= '0;
         nxt_q     <= '0;
         dptr_q    <= '0;
         cnt_q     <= '0;
         rem_q     <= '0;
         hold_q    <= 1'b0;
         recheck_q <= 1'b0;
      end else if (init_take) begin
         cur_q     <= base_addr;
         recheck_q <= 1'b0;
         st_q      <= S_RD_CTL;
      end else begin
         unique case (st_q)
            S_IDLE: ;
            S_RD_CTL: if (req_ready) st_q <= S_WT_CTL;
            S_WT_CTL: if (rsp_valid) begin
               hold_q <= rsp_data[DW-1];
               // a re-check keeps the count of the completed descriptor (R9)
               if (!recheck_q) cnt_q <= rsp_data[CW-1:0];
               st_q <= S_RD_NXT;
            end
            S_RD_NXT: if (req_ready) st_q <= S_WT_NXT;
            S_WT_NXT: if (rsp_valid) begin
               nxt_q <= rsp_data[AW-1:0];
               if (recheck_q) begin
                  if (hold_q) st_q <= S_PARK;
                  else begin
                     cur_q     <= rsp_data[AW-1:0];
                     recheck_q <= 1'b0;
                     st_q      <= S_RD_CTL;
                  end
               end else if (cnt_q == '0) begin
                  st_q <= S_WR_STS;            // R11: no buffer or data reads
               end else begin
                  st_q <= S_RD_BUF;
               end
            end
            S_RD_BUF: if (req_ready) st_q <= S_WT_BUF;
            S_WT_BUF: if (rsp_valid) begin
               dptr_q <= {rsp_data[AW-1:OFSH], {OFSH{1'b0}}};
               rem_q  <= cnt_q;
               st_q   <= S_RD_DAT;
            end
            S_RD_DAT: if (req_ready) st_q <= S_WT_DAT;
            S_WT_DAT: if (rsp_valid) begin
               rem_q  <= rem_q - CW'(take_n);
               dptr_q <= dptr_q + WSTEP;
               st_q   <= S_EMIT;
            end
            S_EMIT: if (!up_busy) st_q <= (rem_q == '0) ? S_WR_STS : S_RD_DAT;
            S_WR_STS: if (req_ready) st_q <= S_DONE;
            S_DONE: begin
               if (hold_q) st_q <= S_PARK;     // R8
               else begin
                  cur_q <= nxt_q;              // R7
                  st_q  <= S_RD_CTL;
               end
            end
            S_PARK: if (poll_pend) begin        // R9, R10
               recheck_q <= 1'b1;
               st_q      <= S_RD_CTL;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_valid = 1'b0;
      req_we    = 1'b0;
      req_addr  = cur_q;
      unique case (st_q)
         S_RD_CTL: begin req_valid = 1'b1; req_addr = cur_q;           end
         S_RD_NXT: begin req_valid = 1'b1; req_addr = cur_q + OFS_NXT; end
         S_RD_BUF: begin req_valid = 1'b1; req_addr = cur_q + OFS_BUF; end
         S_RD_DAT: begin req_valid = 1'b1; req_addr = dptr_q;          end
         S_WR_STS: begin req_valid = 1'b1; req_we = 1'b1;
                         req_addr  = cur_q + OFS_STS;                  end
         default: ;
      endcase
   end

   // status: completion flag in the top bit, count in the low field (R5)
   always_comb begin
      req_wdata           = '0;
      req_wdata[DW-1]     = 1'b1;
      req_wdata[CW-1:0]   = cnt_q;
   end

   assign up_load   = (st_q == S_WT_DAT) && rsp_valid;
   assign up_word   = rsp_data;
   assign up_nbytes = take_n;
   assign up_flush  = init_take && (st_q == S_EMIT);
   assign irq       = (st_q == S_DONE);
   assign parked    = (st_q == S_PARK);
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma #(
   parameter int AW           = 32,
   parameter int DW           = 32,
   parameter int CW           = 16,
   parameter bit SHIFT_UNPACK = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init_req,
   input  logic [AW-1:0]  base_addr,
   input  logic           poll_req,
   output logic           mem_req_valid,
   input  logic           mem_req_ready,
   output logic           mem_req_we,
   output logic [AW-1:0]  mem_req_addr,
   output logic [DW-1:0]  mem_req_wdata,
   input  logic           mem_rsp_valid,
   input  logic [DW-1:0]  mem_rsp_data,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [7:0]     out_data,
   output logic           irq_done
);
   localparam int BPW = DW / 8;
   localparam int NBW = $clog2(BPW + 1);

   if (DW % 8 != 0 || DW < 16) begin : g_bad_dw
      $error("DW must be a multiple of 8 and at least 16");
   end
   if ((BPW & (BPW - 1)) != 0) begin : g_bad_bpw
      $error("DW/8 must be a power of two");
   end
   if (AW > DW || AW < 4) begin : g_bad_aw
      $error("AW must fit in a data word and be at least 4");
   end
   if (CW >= DW || CW < 1) begin : g_bad_cw
      $error("CW must be narrower than DW");
   end

   logic poll_pend_w, init_pend_w, poll_take_w, init_take_w;
   logic up_load_w, up_flush_w, up_busy_w, parked_w;
   logic [DW-1:0]  up_word_w;
   logic [NBW-1:0] up_nbytes_w;

   txd_cmd_latch u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_req  (poll_req),
      .init_req  (init_req),
      .poll_take (poll_take_w),
      .init_take (init_take_w),
      .poll_pend (poll_pend_w),
      .init_pend (init_pend_w)
   );

   txd_walker #(.AW(AW), .DW(DW), .CW(CW)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_addr (base_addr),
      .poll_pend (poll_pend_w),
      .init_pend (init_pend_w),
      .poll_take (poll_take_w),
      .init_take (init_take_w),
      .req_valid (mem_req_valid),
      .req_ready (mem_req_ready),
      .req_we    (mem_req_we),
      .req_addr  (mem_req_addr),
      .req_wdata (mem_req_wdata),
      .rsp_valid (mem_rsp_valid),
      .rsp_data  (mem_rsp_data),
      .up_load   (up_load_w),
      .up_word   (up_word_w),
      .up_nbytes (up_nbytes_w),
      .up_flush  (up_flush_w),
      .up_busy   (up_busy_w),
      .irq       (irq_done),
      .parked    (parked_w)
   );

   txd_unpack #(.DW(DW), .SHIFT_MODE(SHIFT_UNPACK)) u_unp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (up_load_w),
      .word      (up_word_w),
      .nbytes    (up_nbytes_w),
      .flush     (up_flush_w),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .busy      (up_busy_w)
   );
endmodule

// File: rtl/txd_chain_dma_chk.sv
module txd_chain_dma_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          init_req,
   input logic          init_pend,
   input logic          poll_pend,
   input logic          parked,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_we,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] req_wdata,
   input logic          out_valid,
   input logic          out_ready,
   input logic [7:0]    out_data,
   input logic          irq
);
   p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
                                  $stable(req_we) && $stable(req_wdata));

   p_out_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !init_req && !init_pend |=>
         out_valid && $stable(out_data));

   p_park_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      parked && !poll_pend |-> !req_valid);

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(req_valid && req_ready && req_we));

   p_sts_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_we |-> req_wdata[DW-1]);
endmodule

bind txd_chain_dma txd_chain_dma_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .init_req  (init_req),
   .init_pend (init_pend_w),
   .poll_pend (poll_pend_w),
   .parked    (parked_w),
   .req_valid (mem_req_valid),
   .req_ready (mem_req_ready),
   .req_we    (mem_req_we),
   .req_addr  (mem_req_addr),
   .req_wdata (mem_req_wdata),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .irq       (irq_done)
);

// File: tb/txd_chain_dma_test.sv
module txd_chain_dma_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        init_req, poll_req;
   logic [31:0] base_addr;
   logic        mem_req_valid, mem_req_ready, mem_req_we;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        out_valid, out_ready;
   logic [7:0]  out_data;
   logic        irq_done;

   always #4 clk = ~clk;   // 125 MHz

   txd_chain_dma uut (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .base_addr(base_addr),
      .poll_req(poll_req), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .irq_done(irq_done)
   );

   int errs = 0, checks = 0;
   logic [31:0] mem [0:4095];
   logic [7:0]  exp_q [$];
   logic [31:0] rlog [$];
   int irq_cnt = 0, wr_cnt = 0, reads_total = 0, out_cnt = 0;
   bit stream_en = 1'b1, stream_chk = 1'b1;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_sts(input int cnt);
      return 32'h8000_0000 | (cnt & 32'hFFFF);
   endfunction

   // memory, stream and interrupt model: everything sampled and driven at negedge
   initial begin
      bit pv, pr, pwe, pend, ov, orr;
      logic [31:0] pa, pd, ra;
      logic [7:0]  ob, e;
      int lat;
      pv = 0; pr = 0; pwe = 0; pend = 0; ov = 0; orr = 0; lat = 0;
      pa = 0; pd = 0; ra = 0; ob = 0;
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; out_ready = 0;
      forever begin
         @(negedge clk);
         if (pv && pr) begin
            if (pwe) begin mem[pa[13:2]] = pd; wr_cnt++; end
            else begin
               pend = 1; lat = 1 + int'($urandom % 3); ra = pa;
               rlog.push_back(pa); reads_total++;
            end
         end else if (pv && !pr) begin
            chk(mem_req_valid && mem_req_addr == pa && mem_req_we == pwe &&
                mem_req_wdata == pd, "R12", "request held while stalled",
                mem_req_addr, pa);
         end
         mem_rsp_valid = 0;
         if (pend) begin
            lat--;
            if (lat == 0) begin
               mem_rsp_valid = 1; mem_rsp_data = mem[ra[13:2]]; pend = 0;
            end
         end
         mem_req_ready = ($urandom % 10) < 7;
         pv = mem_req_valid; pr = mem_req_ready; pa = mem_req_addr;
         pwe = mem_req_we; pd = mem_req_wdata;

         if (ov && orr) begin
            out_cnt++;
            if (stream_chk) begin
               if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", ob, 0);
               else begin
                  e = exp_q.pop_front();
                  chk(ob == e, "R4", "stream byte", ob, e);
               end
            end
         end
         out_ready = stream_en && (($urandom % 4) != 0);
         ov = out_valid; orr = out_ready; ob = out_data;
         if (irq_done) irq_cnt++;
      end
   end

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wait_irq(input int target);
      for (int n = 0; n < 20000 && irq_cnt < target; n++) @(posedge clk);
   endtask

   task automatic pulse_init(input logic [31:0] b);
      @(negedge clk); base_addr = b; init_req = 1;
      @(negedge clk); init_req = 0;
   endtask

   task automatic pulse_poll();
      @(negedge clk); poll_req = 1;
      @(negedge clk); poll_req = 0;
   endtask

   task automatic set_desc(input logic [31:0] a, input bit hold, input int cnt,
                           input logic [31:0] nxt, input logic [31:0] buff);
      @(posedge clk);
      mem[a[13:2]]     = {hold, 15'd0, 16'(cnt)};
      mem[a[13:2] + 1] = nxt;
      mem[a[13:2] + 2] = buff;
      mem[a[13:2] + 3] = 32'h0;
   endtask

   task automatic fill_buf(input logic [31:0] buff, input int cnt, input bit push);
      @(posedge clk);
      for (int k = 0; k < cnt; k++) begin
         logic [7:0] b;
         b = 8'($urandom);
         mem[buff[13:2] + 12'(k / 4)][8*(k % 4) +: 8] = b;
         if (push) exp_q.push_back(b);
      end
   endtask

   task automatic chk_reads(input logic [31:0] e [$], input string rq);
      bit ok;
      ok = (rlog.size() == e.size());
      for (int i = 0; ok && i < e.size(); i++) if (rlog[i] != e[i]) ok = 0;
      chk(ok, rq, "read address sequence (length)", rlog.size(), e.size());
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL ALL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] eq [$];
      int i0, r0, w0, n;
      bit bad;
      void'($urandom(32'd2718));
      for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
      rst_n = 0; init_req = 0; poll_req = 0; base_addr = 0;
      settle(5);
      @(negedge clk) rst_n = 1;

      // R1: quiet after reset
      bad = 0;
      repeat (20) @(negedge clk) if (mem_req_valid || out_valid || irq_done) bad = 1;
      chk(!bad, "R1", "activity before init", bad, 0);
      chk(rlog.size() == 0, "R1", "reads before init", rlog.size(), 0);

      // R2 R3 R4 R5 R6 R8: one held descriptor of 7 bytes
      set_desc(32'h100, 1, 7, 32'h0, 32'h400);
      fill_buf(32'h400, 7, 1);
      rlog.delete();
      pulse_init(32'h100);
      wait_irq(1); settle(30);
      eq = '{32'h100, 32'h104, 32'h108, 32'h400, 32'h404};
      chk_reads(eq, "R3");
      chk(exp_q.size() == 0, "R4", "bytes left unsent", exp_q.size(), 0);
      chk(mem[32'h10C >> 2] == exp_sts(7), "R5", "status word", mem[32'h10C >> 2], exp_sts(7));
      chk(irq_cnt == 1, "R6", "interrupt count", irq_cnt, 1);
      r0 = reads_total; settle(60);
      chk(reads_total == r0, "R8", "reads while parked", reads_total, r0);

      // R9: poll with flag still set re-reads two words, no irq, no write
      rlog.delete(); w0 = wr_cnt;
      pulse_poll(); settle(40);
      eq = '{32'h100, 32'h104};
      chk_reads(eq, "R9");
      chk(irq_cnt == 1, "R9", "no interrupt on recheck", irq_cnt, 1);
      chk(wr_cnt == w0, "R9", "no status write on recheck", wr_cnt, w0);

      // R7 R11: clear flag, branch to a zero-length dummy that holds
      set_desc(32'h200, 1, 0, 32'h200, 32'h0DE0);
      @(posedge clk); mem[32'h100 >> 2] = 32'd7; mem[32'h104 >> 2] = 32'h200;
      rlog.delete();
      pulse_poll(); wait_irq(2); settle(30);
      eq = '{32'h100, 32'h104, 32'h200, 32'h204};
      chk_reads(eq, "R11");
      chk(mem[32'h20C >> 2] == exp_sts(0), "R11", "dummy status", mem[32'h20C >> 2], exp_sts(0));
      chk(irq_cnt == 2, "R6", "interrupt for zero-length", irq_cnt, 2);

      // R9 R7: dummy relinked to a new descriptor
      set_desc(32'h300, 1, 5, 32'h0, 32'h480);
      fill_buf(32'h480, 5, 1);
      @(posedge clk); mem[32'h200 >> 2] = 32'h0; mem[32'h204 >> 2] = 32'h300;
      rlog.delete();
      pulse_poll(); wait_irq(3); settle(30);
      eq = '{32'h200, 32'h204, 32'h300, 32'h304, 32'h308, 32'h480, 32'h484};
      chk_reads(eq, "R7");
      chk(exp_q.size() == 0, "R4", "relinked bytes", exp_q.size(), 0);
      chk(mem[32'h30C >> 2] == exp_sts(5), "R5", "status word", mem[32'h30C >> 2], exp_sts(5));

      // R11: self-looping dummy walked repeatedly, then held
      @(posedge clk); mem[32'h204 >> 2] = 32'h200; mem[32'h20C >> 2] = 0;
      i0 = irq_cnt;
      pulse_init(32'h200); settle(150);
      @(posedge clk); mem[32'h200 >> 2] = 32'h8000_0000;
      settle(80);
      chk(irq_cnt - i0 >= 3, "R11", "repeated dummy completions", irq_cnt - i0, 3);
      chk(mem[32'h20C >> 2] == exp_sts(0), "R11", "dummy status", mem[32'h20C >> 2], exp_sts(0));
      r0 = reads_total; settle(50);
      chk(reads_total == r0, "R8", "reads while parked on dummy", reads_total, r0);

      // R10: poll arrives while the held descriptor is still streaming
      set_desc(32'h500, 1, 12, 32'h600, 32'h4C0);
      fill_buf(32'h4C0, 12, 1);
      set_desc(32'h600, 1, 3, 32'h0, 32'h4E0);
      fill_buf(32'h4E0, 3, 1);
      i0 = irq_cnt; rlog.delete();
      pulse_init(32'h500);
      for (int t = 0; t < 2000 && rlog.size() < 3; t++) @(posedge clk);
      @(posedge clk); mem[32'h500 >> 2] = 32'd12;
      pulse_poll();
      wait_irq(i0 + 2); settle(30);
      chk(exp_q.size() == 0, "R10", "both descriptors streamed", exp_q.size(), 0);
      chk(irq_cnt - i0 == 2, "R10", "interrupts", irq_cnt - i0, 2);
      chk(mem[32'h60C >> 2] == exp_sts(3), "R5", "status word", mem[32'h60C >> 2], exp_sts(3));

      // R2: init while a long descriptor is mid-stream
      set_desc(32'h700, 1, 40, 32'h0, 32'h800);
      fill_buf(32'h800, 40, 0);
      stream_chk = 0;
      n = out_cnt;
      pulse_init(32'h700);
      for (int t = 0; t < 3000 && out_cnt < n + 6; t++) @(posedge clk);
      @(negedge clk) stream_en = 0;
      settle(4);
      set_desc(32'h780, 1, 6, 32'h0, 32'h840);
      fill_buf(32'h840, 6, 1);
      i0 = irq_cnt;
      @(negedge clk) stream_chk = 1;
      pulse_init(32'h780); settle(10);
      @(negedge clk) stream_en = 1;
      wait_irq(i0 + 1); settle(30);
      chk(exp_q.size() == 0, "R2", "new list streamed", exp_q.size(), 0);
      chk(mem[32'h70C >> 2] == 0, "R2", "abandoned status untouched", mem[32'h70C >> 2], 0);
      chk(mem[32'h78C >> 2] == exp_sts(6), "R5", "status word", mem[32'h78C >> 2], exp_sts(6));
      chk(irq_cnt - i0 == 1, "R6", "interrupt count", irq_cnt - i0, 1);

      // random chains: R4 R5 R6 R7 R11
      for (int rnd = 0; rnd < 6; rnd++) begin
         int cnts [6];
         n = 1 + int'($urandom % 6);
         for (int d = 0; d < n; d++) begin
            cnts[d] = (($urandom % 4) == 0) ? 0 : int'($urandom % 24);
            set_desc(32'h1000 + 32'(d) * 32'h20, (d == n - 1), cnts[d],
                     32'h1000 + 32'(d + 1) * 32'h20, 32'h2000 + 32'(d) * 32'h40);
            fill_buf(32'h2000 + 32'(d) * 32'h40, cnts[d], 1);
         end
         i0 = irq_cnt;
         pulse_init(32'h1000);
         wait_irq(i0 + n); settle(40);
         chk(exp_q.size() == 0, "R4", "random chain bytes", exp_q.size(), 0);
         chk(irq_cnt - i0 == n, "R6", "random chain interrupts", irq_cnt - i0, n);
         for (int d = 0; d < n; d++)
            chk(mem[(32'h100C + 32'(d) * 32'h20) >> 2] == exp_sts(cnts[d]), "R5",
                "random chain status", mem[(32'h100C + 32'(d) * 32'h20) >> 2], exp_sts(cnts[d]));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule